// File: doc/BRIEF.md
# Ordered Receive Mailbox Bank

The block holds twelve receive mailboxes for a CAN controller. It lets a reader drain them in the order the frames arrived, even though the storage side always writes a new frame into the lowest free slot. The protocol core presents a complete, already filtered frame on the write port. The bank places it in the lowest-numbered slot whose ready bit is clear. The last slot never refuses a frame: it overwrites an unread frame and records an overflow.

Ordering comes from the re-arm policy. The reader holds a pointer. Each read request returns the first ready slot at or above the pointer and then moves the pointer past that slot. Slots 0 to 7 form the lower group. A lower slot stays occupied after it is read, so later frames fall into higher slots, and the whole lower group is freed in a single step when slot 7 is read. Slots 8 to 11 act as overflow slots. Each of them is freed as soon as it is read. When the search finds nothing at or above the pointer and the pointer is in the upper group, the same request restarts the search at slot 0.

Per-slot interrupt lines show ready slots whose interrupt is enabled. A separate re-arm port lets the host free any set of slots directly.

Top module: `rx_mailbox_bank`

## Requirements
- R1: A frame write goes to the lowest-numbered slot among 0 to 10 whose ready bit is clear or is being re-armed in the same cycle, and otherwise to slot 11. The chosen slot's bit in `ready_vec` is set from the cycle after the write.
- R2: A write to slot 11 while it is ready, and not re-armed in that cycle, replaces its frame and sets `last_ovf`. A read of slot 11 returns that flag on `rd_overflow`.
- R3: The stored identifier word carries the extended flag in bit 29. An extended frame keeps its 29-bit ID in bits 28:0. A standard frame keeps `frm_id[10:0]` in bits 28:18 with all other bits zero. RTR, DLC and both data words are stored unchanged.
- R4: A read request yields `rd_valid` one cycle later. On a hit, `rd_slot` and the frame show the first ready slot at or above the pointer, and the pointer becomes that slot plus one. Without a hit, `rd_hit` is 0.
- R5: Reading a slot of 0 to 6 leaves it ready. Reading slot 7 clears the ready bits of slots 0 to 7 together.
- R6: Reading a slot of 8 to 11 clears that slot's ready bit, and only that one.
- R7: When no ready slot lies at or above the pointer and the pointer is 8 or more, the same request searches again from slot 0, and the pointer is reset to 0 if that search also misses.
- R8: `order_warn` is high while the pointer is 8 or more and any of slots 0 to 7 is ready.
- R9: `irq_vec` is `ready_vec` masked by an enable set. The enable set is all ones after reset, is cleared by a read that hits, and after a read that misses holds exactly the slots at or above the new pointer.
- R10: With `rearm_valid` high, each slot set in `rearm_mask` has its ready bit and overflow flag cleared before a write in the same cycle is placed. With `rearm_valid` low, the mask has no effect.
- R11: A burst of up to twelve frames written with no reads in between is returned by consecutive reads in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame write strobe from the protocol core |
| frm_ext | input | 1 | Frame uses an extended identifier |
| frm_id | input | 29 | Identifier (standard ID in bits 10:0) |
| frm_rtr | input | 1 | Remote request flag |
| frm_dlc | input | 4 | Data length code |
| frm_data_lo | input | 32 | Data bytes 0 to 3 |
| frm_data_hi | input | 32 | Data bytes 4 to 7 |
| ready_vec | output | 12 | Per-slot ready bits |
| irq_vec | output | 12 | Per-slot interrupt lines |
| rearm_valid | input | 1 | Host re-arm strobe |
| rearm_mask | input | 12 | Slots to free on a host re-arm |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read response present |
| rd_hit | output | 1 | Response carries a frame |
| rd_slot | output | 4 | Slot that was read |
| rd_id_word | output | 32 | Identifier word of the read frame |
| rd_rtr | output | 1 | RTR flag of the read frame |
| rd_dlc | output | 4 | DLC of the read frame |
| rd_data_lo | output | 32 | Data bytes 0 to 3 of the read frame |
| rd_data_hi | output | 32 | Data bytes 4 to 7 of the read frame |
| rd_overflow | output | 1 | Overflow flag of the read slot |
| order_warn | output | 1 | Arrival order cannot be guaranteed |
| last_ovf | output | 1 | Overflow flag of slot 11 |

## Verification
Writes, re-arms and read-side pointer moves all land on the clock edge that samples them. `ready_vec`, `last_ovf`, `order_warn` and `irq_vec` therefore reflect a stimulus one edge after it is driven. A read response appears on the `rd_*` outputs in that same cycle. The bench drives each input set shortly after an edge, advances its reference state at the following edge, and compares one time unit later, so every check lands in the first cycle where its result is due. Directed bursts, a thirteenth-frame overflow and the pointer wrap are followed by a seeded random mix of writes, reads and host re-arms.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

  typedef struct packed {
    logic [31:0] idw;
    logic        rtr;
    logic [3:0]  dlc;
    logic [31:0] lo;
    logic [31:0] hi;
  } rxmb_frame_t;

  function automatic logic [31:0] pack_id(input logic ext, input logic [28:0] id);
    logic [31:0] w;
    w = '0;
    w[29] = ext;
    if (ext) w[28:0] = id;
    else     w[28:18] = id[10:0];
    return w;
  endfunction

endpackage

// File: rtl/rxmb_alloc.sv
module rxmb_alloc #(
  parameter int N_SLOT = 12,
  localparam int SW = $clog2(N_SLOT)
) (
  input  logic [N_SLOT-1:0] ready,
  input  logic [N_SLOT-1:0] rearm,
  output logic [N_SLOT-1:0] target
);
  logic [SW-1:0] idx;
  logic          found;

  always_comb begin
    idx   = SW'(N_SLOT - 1);
    found = 1'b0;
    for (int i = 0; i < N_SLOT - 1; i++) begin
      if (!found && (!ready[i] || rearm[i])) begin
        idx   = SW'(i);
        found = 1'b1;
      end
    end
    target = '0;
    target[idx] = 1'b1;
  end
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store
  import rxmb_pkg::*;
#(
  parameter int N_SLOT = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [N_SLOT-1:0]   wr_target,
  input  rxmb_frame_t         wr_frame,
  input  logic [N_SLOT-1:0]   rearm,
  output logic [N_SLOT-1:0]   ready,
  output logic [N_SLOT-1:0]   ovf,
  output rxmb_frame_t         frames [N_SLOT]
);
  logic [N_SLOT-1:0] ready_d, ovf_d, wr_sel;

  assign wr_sel = wr_target & {N_SLOT{wr_en}};

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    if (g == N_SLOT - 1) begin : g_overwrite
      always_comb begin
        ovf_d[g] = (ovf[g] && !rearm[g]) || (wr_sel[g] && ready[g] && !rearm[g]);
      end
    end else begin : g_normal
      always_comb ovf_d[g] = 1'b0;
    end

    always_comb ready_d[g] = (ready[g] && !rearm[g]) || wr_sel[g];

    always_ff @(posedge clk) begin
      if (wr_sel[g]) frames[g] <= wr_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= '0;
      ovf   <= '0;
    end else begin
      ready <= ready_d;
      ovf   <= ovf_d;
    end
  end
endmodule

// File: rtl/rxmb_reader.sv
module rxmb_reader
  import rxmb_pkg::*;
#(
  parameter int N_SLOT = 12,
  parameter int N_LOW  = 8,
  localparam int SW = $clog2(N_SLOT),
  localparam int PW = $clog2(N_SLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [N_SLOT-1:0] ready,
  input  logic [N_SLOT-1:0] ovf,
  input  rxmb_frame_t       frames [N_SLOT],
  output logic [N_SLOT-1:0] rearm_int,
  output logic [PW-1:0]     ptr_q,
  output logic [N_SLOT-1:0] irq_en_q,
  output logic              order_warn,
  output logic              rd_valid_q,
  output logic              rd_hit_q,
  output logic [SW-1:0]     rd_slot_q,
  output rxmb_frame_t       rd_frame_q,
  output logic              rd_ovf_q
);
  logic [SW:0]       scan_a, scan_b;
  logic              wrap, hit, take;
  logic [SW-1:0]     idx;
  logic [PW-1:0]     ptr_d;
  logic [N_SLOT-1:0] en_d;

  function automatic logic [SW:0] scan(input logic [N_SLOT-1:0] v, input logic [PW-1:0] from);
    logic [SW:0] r;
    r = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (!r[SW] && v[i] && (i >= int'(from))) r = {1'b1, SW'(i)};
    end
    return r;
  endfunction

  always_comb begin
    scan_a = scan(ready, ptr_q);
    scan_b = scan(ready, '0);
    wrap   = !scan_a[SW] && (ptr_q >= PW'(N_LOW));
    hit    = scan_a[SW] || (wrap && scan_b[SW]);
    idx    = scan_a[SW] ? scan_a[SW-1:0] : scan_b[SW-1:0];
    take   = rd_req && hit;

    rearm_int = '0;
    if (take) begin
      if (idx == SW'(N_LOW - 1))  rearm_int[N_LOW-1:0] = '1;
      else if (idx >= SW'(N_LOW)) rearm_int[idx] = 1'b1;
    end

    ptr_d = ptr_q;
    en_d  = irq_en_q;
    if (rd_req) begin
      if (hit) begin
        ptr_d = PW'(idx) + PW'(1);
        en_d  = '0;
      end else begin
        if (wrap) ptr_d = '0;
        for (int i = 0; i < N_SLOT; i++) en_d[i] = (i >= int'(ptr_d));
      end
    end

    order_warn = (ptr_q >= PW'(N_LOW)) && (|ready[N_LOW-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      irq_en_q   <= '1;
      rd_valid_q <= 1'b0;
      rd_hit_q   <= 1'b0;
    end else begin
      ptr_q      <= ptr_d;
      irq_en_q   <= en_d;
      rd_valid_q <= rd_req;
      rd_hit_q   <= take;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      rd_slot_q  <= idx;
      rd_frame_q <= frames[idx];
      rd_ovf_q   <= ovf[idx];
    end
  end
endmodule

// File: rtl/rx_mailbox_bank.sv
module rx_mailbox_bank
  import rxmb_pkg::*;
#(
  parameter int N_SLOT = 12,
  parameter int N_LOW  = 8,
  localparam int SW = $clog2(N_SLOT),
  localparam int PW = $clog2(N_SLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic              frm_ext,
  input  logic [28:0]       frm_id,
  input  logic              frm_rtr,
  input  logic [3:0]        frm_dlc,
  input  logic [31:0]       frm_data_lo,
  input  logic [31:0]       frm_data_hi,
  output logic [N_SLOT-1:0] ready_vec,
  output logic [N_SLOT-1:0] irq_vec,
  input  logic              rearm_valid,
  input  logic [N_SLOT-1:0] rearm_mask,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic              rd_hit,
  output logic [SW-1:0]     rd_slot,
  output logic [31:0]       rd_id_word,
  output logic              rd_rtr,
  output logic [3:0]        rd_dlc,
  output logic [31:0]       rd_data_lo,
  output logic [31:0]       rd_data_hi,
  output logic              rd_overflow,
  output logic              order_warn,
  output logic              last_ovf
);
  rxmb_frame_t       wr_frame, rd_frame;
  rxmb_frame_t       frames [N_SLOT];
  logic [N_SLOT-1:0] rearm_int, rearm_all, target, ovf, irq_en;
  logic [PW-1:0]     rd_ptr;

  always_comb begin
    wr_frame.idw = pack_id(frm_ext, frm_id);
    wr_frame.rtr = frm_rtr;
    wr_frame.dlc = frm_dlc;
    wr_frame.lo  = frm_data_lo;
    wr_frame.hi  = frm_data_hi;
    rearm_all    = (rearm_valid ? rearm_mask : '0) | rearm_int;
  end

  rxmb_alloc #(.N_SLOT(N_SLOT)) u_alloc (
    .ready  (ready_vec),
    .rearm  (rearm_all),
    .target (target)
  );

  rxmb_store #(.N_SLOT(N_SLOT)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (frm_valid),
    .wr_target (target),
    .wr_frame  (wr_frame),
    .rearm     (rearm_all),
    .ready     (ready_vec),
    .ovf       (ovf),
    .frames    (frames)
  );

  rxmb_reader #(.N_SLOT(N_SLOT), .N_LOW(N_LOW)) u_reader (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .ready      (ready_vec),
    .ovf        (ovf),
    .frames     (frames),
    .rearm_int  (rearm_int),
    .ptr_q      (rd_ptr),
    .irq_en_q   (irq_en),
    .order_warn (order_warn),
    .rd_valid_q (rd_valid),
    .rd_hit_q   (rd_hit),
    .rd_slot_q  (rd_slot),
    .rd_frame_q (rd_frame),
    .rd_ovf_q   (rd_overflow)
  );

  assign irq_vec    = ready_vec & irq_en;
  assign last_ovf   = ovf[N_SLOT-1];
  assign rd_id_word = rd_frame.idw;
  assign rd_rtr     = rd_frame.rtr;
  assign rd_dlc     = rd_frame.dlc;
  assign rd_data_lo = rd_frame.lo;
  assign rd_data_hi = rd_frame.hi;
endmodule

// File: rtl/rxmb_bank_chk.sv
module rxmb_bank_chk #(
  parameter int N_SLOT = 12,
  parameter int N_LOW  = 8,
  localparam int SW = $clog2(N_SLOT),
  localparam int PW = $clog2(N_SLOT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic [N_SLOT-1:0] ready_vec,
  input logic [N_SLOT-1:0] rearm_all,
  input logic              rd_req,
  input logic              rd_valid,
  input logic              rd_hit,
  input logic [SW-1:0]     rd_slot,
  input logic [PW-1:0]     rd_ptr,
  input logic              last_ovf
);
  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ready_vec) & ~ready_vec & ~$past(rearm_all)) == '0));

  // R1
  one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ready_vec & ~$past(ready_vec)) <= 1);

  // R1
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !(&ready_vec) && rearm_all == '0) |=>
      $countones(ready_vec & ~$past(ready_vec)) == 1);

  // R4
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R4
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_hit) |-> (rd_ptr == PW'(rd_slot) + PW'(1)));

  // R2
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_ovf) |-> $past(frm_valid && ready_vec[N_SLOT-1]));
endmodule

bind rx_mailbox_bank rxmb_bank_chk #(.N_SLOT(N_SLOT), .N_LOW(N_LOW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .ready_vec (ready_vec),
  .rearm_all (rearm_all),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .rd_hit    (rd_hit),
  .rd_slot   (rd_slot),
  .rd_ptr    (rd_ptr),
  .last_ovf  (last_ovf)
);

// File: tb/rx_mailbox_bank_bench.sv
module rx_mailbox_bank_bench;
  localparam int N = 12;
  localparam int NL = 8;

  logic        clk, rst_n;
  logic        frm_valid, frm_ext, frm_rtr;
  logic [28:0] frm_id;
  logic [3:0]  frm_dlc;
  logic [31:0] frm_data_lo, frm_data_hi;
  logic [N-1:0] ready_vec, irq_vec, rearm_mask;
  logic        rearm_valid, rd_req, rd_valid, rd_hit, rd_rtr, rd_overflow, order_warn, last_ovf;
  logic [3:0]  rd_slot, rd_dlc;
  logic [31:0] rd_id_word, rd_data_lo, rd_data_hi;

  int checks = 0;
  int fails  = 0;

  rx_mailbox_bank u_rx_mailbox_bank (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_id(frm_id),
    .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_data_lo(frm_data_lo), .frm_data_hi(frm_data_hi),
    .ready_vec(ready_vec), .irq_vec(irq_vec), .rearm_valid(rearm_valid), .rearm_mask(rearm_mask),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_slot(rd_slot),
    .rd_id_word(rd_id_word), .rd_rtr(rd_rtr), .rd_dlc(rd_dlc), .rd_data_lo(rd_data_lo),
    .rd_data_hi(rd_data_hi), .rd_overflow(rd_overflow), .order_warn(order_warn), .last_ovf(last_ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference state
  logic [N-1:0] m_ready, m_ovf, m_en;
  logic [31:0]  m_idw [N];
  logic [31:0]  m_lo [N];
  logic [31:0]  m_hi [N];
  logic [3:0]   m_dlc [N];
  logic         m_rtr [N];
  int           m_ptr;
  logic         e_valid, e_hit, e_rtr, e_ovf;
  int           e_slot;
  logic [31:0]  e_idw, e_lo, e_hi;
  logic [3:0]   e_dlc;

  function automatic logic [31:0] idword(input logic ext, input logic [28:0] id);
    return ext ? {3'b001, id} : {3'b000, id[10:0], 18'b0};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ready = '0; m_ovf = '0; m_en = '1; m_ptr = 0; e_valid = 0; e_hit = 0;
  endtask

  task automatic model_step();
    int hit_idx;
    int new_ptr;
    logic [N-1:0] ra;
    int tgt;
    hit_idx = -1;
    for (int i = 0; i < N; i++) if (hit_idx < 0 && m_ready[i] && i >= m_ptr) hit_idx = i;
    if (hit_idx < 0 && m_ptr >= NL)
      for (int i = 0; i < N; i++) if (hit_idx < 0 && m_ready[i]) hit_idx = i;
    ra = rearm_valid ? rearm_mask : '0;
    e_valid = rd_req;
    e_hit = rd_req && hit_idx >= 0;
    new_ptr = m_ptr;
    if (rd_req) begin
      if (hit_idx >= 0) begin
        e_slot = hit_idx; e_idw = m_idw[hit_idx]; e_lo = m_lo[hit_idx]; e_hi = m_hi[hit_idx];
        e_dlc = m_dlc[hit_idx]; e_rtr = m_rtr[hit_idx]; e_ovf = m_ovf[hit_idx];
        if (hit_idx == NL - 1) ra[NL-1:0] = '1;
        else if (hit_idx >= NL) ra[hit_idx] = 1'b1;
        new_ptr = hit_idx + 1;
        m_en = '0;
      end else begin
        if (m_ptr >= NL) new_ptr = 0;
        for (int i = 0; i < N; i++) m_en[i] = (i >= new_ptr);
      end
    end
    m_ptr = new_ptr;
    tgt = N - 1;
    for (int i = N - 2; i >= 0; i--) if (!m_ready[i] || ra[i]) tgt = i;
    m_ready = m_ready & ~ra;
    m_ovf = m_ovf & ~ra;
    if (frm_valid) begin
      if (m_ready[tgt]) m_ovf[tgt] = 1'b1;
      m_ready[tgt] = 1'b1;
      m_idw[tgt] = idword(frm_ext, frm_id); m_lo[tgt] = frm_data_lo; m_hi[tgt] = frm_data_hi;
      m_dlc[tgt] = frm_dlc; m_rtr[tgt] = frm_rtr;
    end
  endtask

  task automatic compare();
    logic warn;
    warn = (m_ptr >= NL) && (|m_ready[NL-1:0]);
    chk(ready_vec == m_ready, "R1 ready_vec", 64'(ready_vec), 64'(m_ready));
    chk(last_ovf == m_ovf[N-1], "R2 last_ovf", 64'(last_ovf), 64'(m_ovf[N-1]));
    chk(order_warn == warn, "R8 order_warn", 64'(order_warn), 64'(warn));
    chk(irq_vec == (m_ready & m_en), "R9 irq_vec", 64'(irq_vec), 64'(m_ready & m_en));
    chk(rd_valid == e_valid, "R4 rd_valid", 64'(rd_valid), 64'(e_valid));
    if (e_valid) chk(rd_hit == e_hit, "R4 rd_hit", 64'(rd_hit), 64'(e_hit));
    if (e_valid && e_hit) begin
      chk(int'(rd_slot) == e_slot, "R4 rd_slot", 64'(rd_slot), 64'(e_slot));
      chk(rd_id_word == e_idw, "R3 rd_id_word", 64'(rd_id_word), 64'(e_idw));
      chk({rd_rtr, rd_dlc, rd_data_lo, rd_data_hi} == {e_rtr, e_dlc, e_lo, e_hi}, "R3 payload",
          {rd_data_hi, rd_data_lo}, {e_hi, e_lo});
      chk(rd_overflow == e_ovf, "R2 rd_overflow", 64'(rd_overflow), 64'(e_ovf));
    end
  endtask

  task automatic idle();
    frm_valid = 0; rd_req = 0; rearm_valid = 0; rearm_mask = '0;
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    #1;
    compare();
    idle();
  endtask

  task automatic put(input logic ext, input logic [28:0] id);
    frm_valid = 1; frm_ext = ext; frm_id = id; frm_rtr = id[0]; frm_dlc = id[3:0];
    frm_data_lo = {3'b0, id} ^ 32'hA5A5_0000; frm_data_hi = ~{3'b0, id};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    idle();
    frm_ext = 0; frm_id = '0; frm_rtr = 0; frm_dlc = '0; frm_data_lo = '0; frm_data_hi = '0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(ready_vec == '0 && irq_vec == '0 && !rd_valid && !last_ovf && !order_warn,
        "R9 reset state", {ready_vec, irq_vec}, 64'd0);

    // R11 burst of twelve, then a 13th overwrite (R2)
    for (int k = 0; k < N; k++) begin put(k[0], 29'h100 + 29'(k)); step(); end
    chk(ready_vec == '1, "R1 burst fills all", 64'(ready_vec), 64'hFFF);
    put(1'b1, 29'h1ABCDEF); step();
    chk(last_ovf == 1'b1, "R2 thirteenth frame overflow", 64'(last_ovf), 64'd1);
    for (int k = 0; k < N; k++) begin
      rd_req = 1; step();
      chk(int'(rd_slot) == k, "R11 arrival order slot", 64'(rd_slot), 64'(k));
      if (k < N - 1)
        chk(rd_id_word == idword(k[0], 29'h100 + 29'(k)), "R11 arrival order id",
            64'(rd_id_word), 64'(idword(k[0], 29'h100 + 29'(k))));
      if (k == 0) chk(ready_vec[0] == 1'b1, "R5 lower slot kept", 64'(ready_vec[0]), 64'd1);
      if (k == 7) chk(ready_vec[7:0] == '0, "R5 lower group freed", 64'(ready_vec[7:0]), 64'd0);
      if (k == 8) chk(ready_vec[11:8] == 4'b1110, "R6 single upper freed", 64'(ready_vec[11:8]), 64'hE);
    end
    chk(rd_overflow == 1'b1, "R2 overflow on read", 64'(rd_overflow), 64'd1);
    rd_req = 1; step();
    chk(rd_hit == 1'b0 && irq_vec == '0, "R7 empty after wrap", 64'(rd_hit), 64'd0);

    // R7 / R8: pointer in upper group, new lower frame
    for (int k = 0; k < 9; k++) begin put(1'b0, 29'h20 + 29'(k)); step(); end
    for (int k = 0; k < 9; k++) begin rd_req = 1; step(); end
    put(1'b0, 29'h7FF); step();
    chk(order_warn == 1'b1, "R8 order warning", 64'(order_warn), 64'd1);
    rd_req = 1; step();
    chk(rd_hit && rd_slot == 4'd0, "R7 wrap to lower", 64'(rd_slot), 64'd0);

    // R10 host re-arm
    rearm_valid = 1; rearm_mask = '1; step();
    for (int k = 0; k < N + 1; k++) begin put(1'b1, 29'h3000 + 29'(k)); step(); end
    rearm_valid = 0; rearm_mask = '1; step();
    chk(ready_vec == '1 && last_ovf, "R10 mask ignored when not valid", 64'(ready_vec), 64'hFFF);
    put(1'b0, 29'h55); rearm_valid = 1; rearm_mask = 12'h800; step();
    chk(ready_vec[11] && !last_ovf, "R10 re-arm before write", 64'(last_ovf), 64'd0);
    rearm_valid = 1; rearm_mask = '1; step();
    chk(ready_vec == '0, "R10 re-arm all", 64'(ready_vec), 64'd0);

    // random mix
    seed = $urandom(32'h1F2E3D);
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(99) < 40) put(1'($urandom), 29'($urandom));
      if ($urandom_range(99) < 40) rd_req = 1;
      if ($urandom_range(99) < 4) begin rearm_valid = 1; rearm_mask = 12'($urandom); end
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule